// File: doc/BRIEF.md
# Pixel Clock Divider with Bypass

The block turns a reference clock into a pixel-rate timing pair for a display pipeline: a single-cycle enable that marks the start of every pixel period, and a square-ish waveform that can drive a panel clock pin. The rate is set by a divisor field inside a 32-bit control word. The field is split into a low slice and a high slice at different bit positions. The block joins the two slices into one field, adds two, and counts that many reference cycles per pixel period. A separate bypass bit in the same word selects divide-by-one.

Software picks the field value for a target rate. The block only applies it. A changed control word is taken up only when the current period ends, so a rate change never produces a short period or a runt pulse. The divisor in force is reported on a readback port.

Top module: `pixclk_divider`

## Requirements
- R1: While `rst_n` is low, `pix_en` and `pix_clk` are low. In the first cycle after `rst_n` is released, `pix_en` is high and a period of the divisor requested during reset begins.
- R2: With the bypass bit (`ctrl[26]`) clear, the divisor is the 10-bit field `{ctrl[31:27], ctrl[4:0]}` plus 2. `ctrl[31:27]` forms the upper five bits of the field.
- R3: With `ctrl[26]` set, the divisor is 1 whatever the field holds: `pix_en` and `pix_clk` stay high on every cycle.
- R4: `pix_en` is high for exactly one reference cycle per period. Successive `pix_en` pulses are spaced by the active divisor.
- R5: `pix_clk` is high for the first ceil(D/2) cycles of each period and low for the rest. It therefore rises only in a cycle where `pix_en` is high, and for odd D its high phase is one cycle longer than its low phase.
- R6: A new control word takes effect only at the next period start. The period in progress completes with the old divisor, and `div_eff` changes only in a cycle where `pix_en` is high.
- R7: `div_eff` reports the divisor of the period in progress: field plus 2, or 1 in bypass.
- R8: Control bits 25:5 have no effect on the period, the waveform or `div_eff`.
- R9: A field of all ones gives the largest divisor, 1025.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl | input | 32 | Control word: divisor field low slice [4:0], high slice [31:27], bypass [26] |
| pix_en | output | 1 | One-cycle pulse at the start of each pixel period |
| pix_clk | output | 1 | Generated pixel clock waveform, high in the first half of each period |
| div_eff | output | 11 | Divisor of the period in progress |

## Verification
The assertions check, on every cycle, the relations that hold between the outputs:
- `pix_clk` rises only with `pix_en`.
- `pix_en` stays a single-cycle pulse whenever the divisor exceeds one.
- In bypass, both outputs are held high.
- `div_eff` changes only at a period start.

Only the directed scenarios can show the arithmetic. These are the field assembly across the two slices with the offset of two, the exact period length and the high-phase length for even, odd, minimum and maximum divisors, and the insensitivity to the unused control bits. They also show that a change written mid-period lets the old period finish at its full length.

// File: rtl/pcd_pkg.sv
// Shared constants for the pixel clock divider: default placement of the
// divisor slices and the bypass bit inside the control word, and the fixed
// offset added to the assembled field.
package pcd_pkg;
    localparam int unsigned CTRL_W_DEF  = 32;
    localparam int unsigned LO_POS_DEF  = 0;
    localparam int unsigned LO_W_DEF    = 5;
    localparam int unsigned HI_POS_DEF  = 27;
    localparam int unsigned HI_W_DEF    = 5;
    localparam int unsigned BYP_POS_DEF = 26;
    localparam int unsigned DIV_OFFSET  = 2;
endpackage

// File: rtl/pcd_decode.sv
// Control word decoder.
// Joins the low and high divisor slices into one field, with the high slice
// placed directly above the low one, and adds the fixed offset. When the
// bypass bit is set, the field is ignored and the request is 1.
// Assumes: the slices and the bypass bit lie inside the word and do not overlap.
module pcd_decode
    import pcd_pkg::*;
#(
    parameter int unsigned CTRL_W  = CTRL_W_DEF,
    parameter int unsigned LO_POS  = LO_POS_DEF,
    parameter int unsigned LO_W    = LO_W_DEF,
    parameter int unsigned HI_POS  = HI_POS_DEF,
    parameter int unsigned HI_W    = HI_W_DEF,
    parameter int unsigned BYP_POS = BYP_POS_DEF,
    parameter int unsigned DIV_W   = LO_W + HI_W + 1
) (
    input  logic [CTRL_W-1:0] ctrl,
    output logic [DIV_W-1:0]  req_div
);
    localparam int unsigned FLD_W = LO_W + HI_W;

    logic [FLD_W-1:0] field;

    // Rebuild the contiguous divisor field from its two slices.
    assign field = {ctrl[HI_POS +: HI_W], ctrl[LO_POS +: LO_W]};

    // Pick divide-by-one in bypass, otherwise the field plus the offset.
    always_comb begin
        if (ctrl[BYP_POS]) begin
            req_div = DIV_W'(1);
        end else begin
            req_div = DIV_W'(field) + DIV_W'(DIV_OFFSET);
        end
    end
endmodule

// File: rtl/pcd_period.sv
// Period counter.
// Counts reference cycles within one pixel period and holds the divisor in
// force. The requested divisor is loaded only on the last cycle of a period,
// and also during reset. The run flag marks that the first period has started.
// Assumes: req_div is never zero.
module pcd_period #(
    parameter int unsigned DIV_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] req_div,
    output logic [DIV_W-1:0] cnt,
    output logic [DIV_W-1:0] act_div,
    output logic             run
);
    logic last;

    // Final cycle of the running period.
    assign last = (cnt == act_div - DIV_W'(1));

    // Advance the in-period count; swap in the new divisor at the wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            act_div <= req_div;
            run     <= 1'b0;
        end else if (!run) begin
            run <= 1'b1;
        end else if (last) begin
            cnt     <= '0;
            act_div <= req_div;
        end else begin
            cnt <= cnt + DIV_W'(1);
        end
    end
endmodule

// File: rtl/pcd_wave.sv
// Output shaper.
// Derives the period-start enable and the pixel clock waveform from the
// in-period count. The high phase lasts ceil(D/2) cycles, so an odd divisor
// gives a high phase one cycle longer than the low phase.
// Assumes: cnt < act_div while run is high.
module pcd_wave #(
    parameter int unsigned DIV_W = 11
) (
    input  logic [DIV_W-1:0] cnt,
    input  logic [DIV_W-1:0] act_div,
    input  logic             run,
    output logic             pix_en,
    output logic             pix_clk
);
    logic [DIV_W:0] hi_len;

    // Number of high cycles per period, rounded up.
    assign hi_len = ({1'b0, act_div} + (DIV_W+1)'(1)) >> 1;

    // Pulse at the start of each period; waveform high in the first part.
    always_comb begin
        pix_en  = run && (cnt == '0);
        pix_clk = run && ({1'b0, cnt} < hi_len);
    end
endmodule

// File: rtl/pixclk_divider.sv
// Pixel clock divider with bypass (top).
// Decodes the split divisor field from the control word, counts periods of the
// reference clock, and produces a period-start enable, a pixel clock waveform
// and the active divisor for readback. Rate changes apply at period ends only.
// Assumes: ctrl is synchronous to clk; synchronous active-low reset.
module pixclk_divider
    import pcd_pkg::*;
#(
    parameter int unsigned CTRL_W  = CTRL_W_DEF,
    parameter int unsigned LO_POS  = LO_POS_DEF,
    parameter int unsigned LO_W    = LO_W_DEF,
    parameter int unsigned HI_POS  = HI_POS_DEF,
    parameter int unsigned HI_W    = HI_W_DEF,
    parameter int unsigned BYP_POS = BYP_POS_DEF
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [CTRL_W-1:0]    ctrl,
    output logic                 pix_en,
    output logic                 pix_clk,
    output logic [LO_W+HI_W:0]   div_eff
);
    localparam int unsigned DIV_W = LO_W + HI_W + 1;

    logic [DIV_W-1:0] req_div;
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] act_div;
    logic             run;

    pcd_decode #(
        .CTRL_W (CTRL_W),
        .LO_POS (LO_POS),
        .LO_W   (LO_W),
        .HI_POS (HI_POS),
        .HI_W   (HI_W),
        .BYP_POS(BYP_POS),
        .DIV_W  (DIV_W)
    ) u_decode (
        .ctrl   (ctrl),
        .req_div(req_div)
    );

    pcd_period #(
        .DIV_W(DIV_W)
    ) u_period (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_div(req_div),
        .cnt    (cnt),
        .act_div(act_div),
        .run    (run)
    );

    pcd_wave #(
        .DIV_W(DIV_W)
    ) u_wave (
        .cnt    (cnt),
        .act_div(act_div),
        .run    (run),
        .pix_en (pix_en),
        .pix_clk(pix_clk)
    );

    // Readback of the divisor in force.
    assign div_eff = act_div;
endmodule

// File: rtl/pixclk_divider_chk.sv
// Property checker for the pixel clock divider, attached with bind.
// Observes only the top-level ports.
module pixclk_divider_chk #(
    parameter int unsigned DIV_W = 11
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pix_en,
    input logic             pix_clk,
    input logic [DIV_W-1:0] div_eff
);
    logic armed;

    // Marks cycles after the first post-reset edge.
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    p_rise_at_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pix_clk) |-> pix_en);

    p_start_is_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pix_en |-> pix_clk);

    p_single_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_en && div_eff > DIV_W'(1)) |=> !pix_en);

    p_bypass_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && div_eff == DIV_W'(1)) |-> (pix_en && pix_clk));

    p_div_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !$stable(div_eff)) |-> pix_en);

    p_div_nonzero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        div_eff != '0);
endmodule

bind pixclk_divider pixclk_divider_chk #(
    .DIV_W(LO_W + HI_W + 1)
) i_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .pix_en (pix_en),
    .pix_clk(pix_clk),
    .div_eff(div_eff)
);

// File: tb/test_pixclk_divider.sv
// Directed bench for the pixel clock divider. Each task drives one scenario
// and checks its own results. Outputs are sampled on falling edges.
module test_pixclk_divider;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] ctrl;
    logic        pix_en;
    logic        pix_clk;
    logic [10:0] div_eff;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    pixclk_divider i_pixclk_divider (
        .clk    (clk),
        .rst_n  (rst_n),
        .ctrl   (ctrl),
        .pix_en (pix_en),
        .pix_clk(pix_clk),
        .div_eff(div_eff)
    );

    // Record one check and report a mismatch.
    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Build a control word for divisor d (field d-2), bypass flag and filler bits 25:5.
    function automatic logic [31:0] mk_ctrl(input int d, input bit byp, input logic [20:0] fill);
        logic [9:0] f;
        f = 10'(d - 2);
        return {f[9:5], byp, fill, f[4:0]};
    endfunction

    // From a falling edge, find a period start and measure that period and its high phase.
    task automatic measure(output int per, output int hi);
        while (!pix_en) @(negedge clk);
        per = 0;
        hi  = 0;
        do begin
            if (pix_clk) hi++;
            per++;
            @(negedge clk);
        end while (!pix_en);
    endtask

    // R1: outputs quiet in reset, first period starts right after release.
    task automatic t_reset();
        int p, h;
        rst_n = 1'b0;
        ctrl  = mk_ctrl(4, 1'b0, 21'h0);
        repeat (3) @(negedge clk);
        chk(pix_en == 1'b0, "R1 pix_en in reset", int'(pix_en), 0);
        chk(pix_clk == 1'b0, "R1 pix_clk in reset", int'(pix_clk), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(pix_en == 1'b1, "R1 first start after release", int'(pix_en), 1);
        chk(div_eff == 11'd4, "R7 divisor after reset", int'(div_eff), 4);
        measure(p, h);
        chk(p == 4, "R1 first period length", p, 4);
    endtask

    // R2 R4 R5 R7: steady division by d.
    task automatic t_div(input int d, input string tag);
        int p, h;
        ctrl = mk_ctrl(d, 1'b0, 21'h0);
        measure(p, h);
        measure(p, h);
        chk(p == d, {tag, " R2 R4 period"}, p, d);
        chk(h == (d + 1) / 2, {tag, " R5 high phase"}, h, (d + 1) / 2);
        chk(int'(div_eff) == d, {tag, " R7 readback"}, int'(div_eff), d);
    endtask

    // R3: bypass forces divide-by-one and ignores a nonzero field.
    task automatic t_bypass();
        int p, h;
        bit ok;
        ctrl = mk_ctrl(9, 1'b1, 21'h0);
        measure(p, h);
        measure(p, h);
        chk(p == 1, "R3 bypass period", p, 1);
        chk(h == 1, "R3 bypass high", h, 1);
        chk(div_eff == 11'd1, "R3 R7 bypass readback", int'(div_eff), 1);
        ok = 1'b1;
        repeat (6) begin
            @(negedge clk);
            if (!(pix_en && pix_clk)) ok = 1'b0;
        end
        chk(ok, "R3 outputs held high", int'(ok), 1);
    endtask

    // R8: bits 25:5 do not matter.
    task automatic t_filler();
        int p, h;
        ctrl = mk_ctrl(6, 1'b0, 21'h15A5A5);
        measure(p, h);
        measure(p, h);
        chk(p == 6, "R8 period with filler bits", p, 6);
        chk(h == 3, "R8 high phase with filler bits", h, 3);
        chk(div_eff == 11'd6, "R8 readback with filler bits", int'(div_eff), 6);
    endtask

    // R6: a mid-period change lets the current period finish first.
    task automatic t_change();
        int p, h, gap;
        bit held;
        ctrl = mk_ctrl(5, 1'b0, 21'h0);
        measure(p, h);
        measure(p, h);
        gap = 0;
        repeat (2) begin
            @(negedge clk);
            gap++;
        end
        ctrl = mk_ctrl(3, 1'b0, 21'h0);
        held = 1'b1;
        while (!pix_en) begin
            if (div_eff != 11'd5) held = 1'b0;
            @(negedge clk);
            gap++;
        end
        chk(gap == 5, "R6 old period completes", gap, 5);
        chk(held, "R6 readback held mid-period", int'(held), 1);
        chk(div_eff == 11'd3, "R6 new divisor at start", int'(div_eff), 3);
        measure(p, h);
        chk(p == 3, "R6 new period length", p, 3);
    endtask

    // Ends a hung run as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // Scenario sequence.
    initial begin
        rst_n = 1'b0;
        ctrl  = 32'h0;
        @(negedge clk);
        t_reset();
        t_div(2, "min field");
        t_div(3, "odd");
        t_div(7, "odd");
        t_div(34, "high slice only");
        t_div(1025, "R9 max field");
        t_bypass();
        t_div(8, "leave bypass");
        t_filler();
        t_change();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule